// File: doc/BRIEF.md
# Shared Tick Timer with Per-Core Compare

This block is the timer subsystem of a small multiprocessor. A single free-running tick counter is common to every core, so all cores always observe one coherent count. The counter moves forward by one on every cycle in which the tick-enable input is high. At the intended tick rate of 20 MHz, that is one step every 50 ns. Any core may overwrite the shared count through its own write port. Each core reads the same value, and the value it reads includes every tick up to the read.

Each core also owns a control word that holds a mode, an event enable, a sticky event-pending flag and a compare period. A core matches when the low period-width bits of the shared count equal its period. Because only those bits are compared, a match can occur again after the counter wraps within the period field, even when the upper bits differ. On a match the core records an event and then acts according to its mode:

- Restart clears the shared count for everyone.
- One-shot stops that core from counting.
- Continuous keeps counting.
- Disabled never matches.

Top module: `shared_tick_timer`

## Requirements
- R1: After reset the shared count is 0, every control word reads 0 and every event output is low.
- R2: On a cycle with tick_en high, the shared count advances by one when at least one core is running. A core is running when its mode is not disabled and it is not stopped after a one-shot match. When no core is running, the count holds.
- R3: A count write from any core replaces the shared count in the next cycle, and every core's count read port shows the same value. When several cores write in the same cycle, the lowest-numbered core wins. A count write takes precedence over advancing and over a restart clear.
- R4: Control word layout:
  - bits 31:30 hold the mode, encoded 00 disabled, 01 restart, 10 one-shot, 11 continuous;
  - bit 29 is the event enable;
  - bit 28 is the event-pending flag;
  - bits 27:0 are the period.
  A read returns the stored word.
- R5: A running core matches on a tick when bits 27:0 of the count equal its period. The upper count bits are ignored, so the match recurs after the count wraps within the period field. A match sets the core's pending flag.
- R6: In restart mode a match loads the shared count with 0 instead of incrementing, and every core sees the cleared value. When several cores match on the same tick, the count is cleared once and each matching core records its event.
- R7: In one-shot mode a match stops that core. If no other core is running, the count stops. Any later write of that core's control word makes it run again.
- R8: A disabled core never matches, so its pending flag is never set by ticks.
- R9: The pending flag is sticky. A control write with bit 28 = 0 clears it, and a write with bit 28 = 1 keeps its current value. The core's event output equals pending AND event enable.
- R10: In continuous mode a match leaves counting unaffected, and the count keeps incrementing past the match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One timer tick in this cycle |
| cnt_wr_en | input | NUM_CORES | Per-core count write strobe |
| cnt_wr_data | input | NUM_CORES*32 | Per-core count write value, core i in slice i |
| cnt_rd_data | output | NUM_CORES*32 | Per-core count read value (all equal) |
| ctl_wr_en | input | NUM_CORES | Per-core control word write strobe |
| ctl_wr_data | input | NUM_CORES*32 | Per-core control word write value |
| ctl_rd_data | output | NUM_CORES*32 | Per-core control word read value |
| event_o | output | NUM_CORES | Per-core timer event |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Wrap-around match with nonzero upper bits.** A match with the count at 0x10000001 and period 1 exposes a comparator that uses the full count width, because such a design never fires.
- **Simultaneous restart and continuous match.** Two cores match on one tick, one in restart and one in continuous mode. The second core must read a count of 0 and both events must be set; a design that clears per core or drops the non-restart event fails here.
- **One-shot stop and resume.** The count must freeze after a one-shot match and resume after a control rewrite. A design that ignores the stop keeps counting, and one that never clears the stop stays frozen.
- **Same-cycle count writes.** Two cores write the count in the same cycle, exposing a reversed priority.
- **Sticky pending bit.** Writes of 1 and 0 to the pending bit expose a flag that can be set from software or that ignores the clear.

// File: rtl/stt_pkg.sv
package stt_pkg;
  typedef enum logic [1:0] {
    TM_OFF     = 2'b00,
    TM_RESTART = 2'b01,
    TM_ONESHOT = 2'b10,
    TM_FREE    = 2'b11
  } tmode_e;
endpackage

// File: rtl/stt_counter.sv
module stt_counter #(
  parameter int NUM_CORES = 2,
  parameter int CNT_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick_en,
  input  logic                       any_run,
  input  logic                       any_restart,
  input  logic [NUM_CORES-1:0]       wr_en,
  input  logic [NUM_CORES*CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0]           count_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wr_val;
  logic             wr_any;

  // lowest-numbered writer wins: scan downward so it is assigned last
  always_comb begin
    wr_any = |wr_en;
    wr_val = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (wr_en[i]) wr_val = wr_data[i*CNT_W +: CNT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_any) begin
      cnt_q <= wr_val;
    end else if (tick_en && any_run) begin
      cnt_q <= any_restart ? '0 : cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!wr_any && !any_run) |=> $stable(cnt_q)); // R2
  AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (rst)
    (tick_en && any_run && !any_restart && !wr_any) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_en[0]) |=> (cnt_q == $past(wr_data[CNT_W-1:0]))); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick_en && any_run && any_restart && !wr_any) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/stt_core.sv
module stt_core
  import stt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PER_W = 28,
  localparam int REG_W = PER_W + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             running_o,
  output logic             restart_o,
  output logic             event_o
);
  localparam int PEND_B = PER_W;
  localparam int IE_B   = PER_W + 1;

  logic [REG_W-1:0] ctl_q;
  logic             stopped_q;
  tmode_e           mode;
  logic             match;

  assign mode      = tmode_e'(ctl_q[REG_W-1 -: 2]);
  assign running_o = (mode != TM_OFF) && !stopped_q;
  assign match     = tick_en && running_o && (count_i[PER_W-1:0] == ctl_q[PER_W-1:0]);
  assign restart_o = match && (mode == TM_RESTART);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      stopped_q <= 1'b0;
    end else if (wr_en) begin
      ctl_q         <= wr_data;
      ctl_q[PEND_B] <= (wr_data[PEND_B] & ctl_q[PEND_B]) | match;
      stopped_q     <= 1'b0;
    end else if (match) begin
      ctl_q[PEND_B] <= 1'b1;
      if (mode == TM_ONESHOT) stopped_q <= 1'b1;
    end
  end

  assign rd_data = ctl_q;
  assign event_o = ctl_q[PEND_B] & ctl_q[IE_B];

  AST_OFF_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (mode == TM_OFF && !ctl_q[PEND_B] && !wr_en) |=> !ctl_q[PEND_B]); // R8
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (match && mode == TM_ONESHOT && !wr_en) |=> !running_o); // R7
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[PEND_B] && !wr_en) |=> ctl_q[PEND_B]); // R9
  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
    (match && !wr_en) |=> ctl_q[PEND_B]); // R5
endmodule

// File: rtl/shared_tick_timer.sv
module shared_tick_timer #(
  parameter int NUM_CORES = 2,
  parameter int CNT_W     = 32,
  parameter int PER_W     = 28,
  localparam int REG_W    = PER_W + 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick_en,
  input  logic [NUM_CORES-1:0]       cnt_wr_en,
  input  logic [NUM_CORES*CNT_W-1:0] cnt_wr_data,
  output logic [NUM_CORES*CNT_W-1:0] cnt_rd_data,
  input  logic [NUM_CORES-1:0]       ctl_wr_en,
  input  logic [NUM_CORES*REG_W-1:0] ctl_wr_data,
  output logic [NUM_CORES*REG_W-1:0] ctl_rd_data,
  output logic [NUM_CORES-1:0]       event_o
);
  logic [CNT_W-1:0]     count;
  logic [NUM_CORES-1:0] run_vec;
  logic [NUM_CORES-1:0] restart_vec;

  stt_counter #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_counter (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .any_run     (|run_vec),
    .any_restart (|restart_vec),
    .wr_en       (cnt_wr_en),
    .wr_data     (cnt_wr_data),
    .count_o     (count)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    stt_core #(.CNT_W(CNT_W), .PER_W(PER_W)) u_core (
      .clk       (clk),
      .rst       (rst),
      .tick_en   (tick_en),
      .count_i   (count),
      .wr_en     (ctl_wr_en[g]),
      .wr_data   (ctl_wr_data[g*REG_W +: REG_W]),
      .rd_data   (ctl_rd_data[g*REG_W +: REG_W]),
      .running_o (run_vec[g]),
      .restart_o (restart_vec[g]),
      .event_o   (event_o[g])
    );
    assign cnt_rd_data[g*CNT_W +: CNT_W] = count;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (event_o == '0)); // R1
endmodule

// File: tb/shared_tick_timer_tb.sv
module shared_tick_timer_tb;
  localparam int N = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_en = 1'b0;
  logic [N-1:0]  cnt_wr_en = '0;
  logic [N*32-1:0] cnt_wr_data = '0;
  logic [N*32-1:0] cnt_rd_data;
  logic [N-1:0]  ctl_wr_en = '0;
  logic [N*32-1:0] ctl_wr_data = '0;
  logic [N*32-1:0] ctl_rd_data;
  logic [N-1:0]  event_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  shared_tick_timer u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .cnt_rd_data(cnt_rd_data),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .event_o(event_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic        core;
    logic [1:0]  mode;
    logic [27:0] period;
    logic [31:0] start;
    logic [7:0]  ticks;
    logic [31:0] exp_cnt;
    logic        exp_ev;
  } vec_t;

  // modes: 00 off, 01 restart, 10 one-shot, 11 continuous
  localparam vec_t VECS [6] = '{
    '{1'b0, 2'b11, 28'd5, 32'd0,          8'd3, 32'd3,          1'b0}, // R2 R10 before match
    '{1'b0, 2'b11, 28'd5, 32'd0,          8'd6, 32'd6,          1'b1}, // R5 R10 match, keeps counting
    '{1'b0, 2'b01, 28'd4, 32'd0,          8'd5, 32'd0,          1'b1}, // R6 restart clears
    '{1'b1, 2'b10, 28'd2, 32'd0,          8'd6, 32'd3,          1'b1}, // R7 one-shot stops
    '{1'b1, 2'b11, 28'd1, 32'h0FFF_FFFE,  8'd4, 32'h1000_0002,  1'b1}, // R5 wrap match
    '{1'b0, 2'b00, 28'd7, 32'd7,          8'd5, 32'd7,          1'b0}  // R8 R2 disabled
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
    end
  endtask

  task automatic wr_ctl(input logic [N-1:0] en, input logic [31:0] d0, input logic [31:0] d1);
    @(negedge clk);
    ctl_wr_en = en;
    ctl_wr_data = {d1, d0};
    @(negedge clk);
    ctl_wr_en = '0;
  endtask

  task automatic wr_cnt(input logic [N-1:0] en, input logic [31:0] d0, input logic [31:0] d1);
    @(negedge clk);
    cnt_wr_en = en;
    cnt_wr_data = {d1, d0};
    @(negedge clk);
    cnt_wr_en = '0;
  endtask

  function automatic logic [31:0] cw(input logic [1:0] m, input logic ie,
                                     input logic pd, input logic [27:0] p);
    return {m, ie, pd, p};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 count", cnt_rd_data[31:0], 32'd0);
    check("R1 ctl", ctl_rd_data[63:32], 32'd0);
    check("R1 event", {30'd0, event_o}, 32'd0);

    foreach (VECS[k]) begin
      wr_ctl(2'b11, 32'd0, 32'd0);
      wr_cnt(2'b01, VECS[k].start, 32'd0);
      if (VECS[k].core)
        wr_ctl(2'b10, 32'd0, cw(VECS[k].mode, 1'b1, 1'b0, VECS[k].period));
      else
        wr_ctl(2'b01, cw(VECS[k].mode, 1'b1, 1'b0, VECS[k].period), 32'd0);
      ticks(int'(VECS[k].ticks));
      check("R2/R5/R6/R7/R8/R10 vector count", cnt_rd_data[31:0], VECS[k].exp_cnt);
      check("R5/R8/R9 vector event", {31'd0, event_o[VECS[k].core]}, {31'd0, VECS[k].exp_ev});
    end

    // R7 one-shot resumes after a control rewrite
    wr_ctl(2'b11, 32'd0, 32'd0);
    wr_cnt(2'b01, 32'd0, 32'd0);
    wr_ctl(2'b10, 32'd0, cw(2'b10, 1'b1, 1'b0, 28'd1));
    ticks(3);
    check("R7 stopped count", cnt_rd_data[63:32], 32'd2);
    wr_ctl(2'b10, 32'd0, cw(2'b10, 1'b1, 1'b0, 28'd1));
    ticks(1);
    check("R7 resumed count", cnt_rd_data[63:32], 32'd3);

    // R6 restart by core0 seen by continuous core1, both record
    wr_ctl(2'b11, 32'd0, 32'd0);
    wr_cnt(2'b01, 32'd0, 32'd0);
    wr_ctl(2'b11, cw(2'b01, 1'b1, 1'b0, 28'd3), cw(2'b11, 1'b1, 1'b0, 28'd3));
    ticks(4);
    check("R6 core1 sees clear", cnt_rd_data[63:32], 32'd0);
    check("R6 both events", {30'd0, event_o}, 32'd3);
    ticks(1);
    check("R6 single clear then advance", cnt_rd_data[31:0], 32'd1);

    // R3 same-cycle writes: lowest core wins; also beats a tick
    wr_ctl(2'b11, 32'd0, 32'd0);
    wr_cnt(2'b11, 32'h0000_AAAA, 32'h0000_5555);
    check("R3 priority core0", cnt_rd_data[31:0], 32'h0000_AAAA);
    check("R3 coherent core1", cnt_rd_data[63:32], 32'h0000_AAAA);
    wr_ctl(2'b01, cw(2'b11, 1'b0, 1'b0, 28'd100), 32'd0);
    @(negedge clk);
    tick_en = 1'b1;
    cnt_wr_en = 2'b10;
    cnt_wr_data = {32'h0000_1234, 32'd0};
    @(negedge clk);
    tick_en = 1'b0;
    cnt_wr_en = '0;
    check("R3 write beats tick", cnt_rd_data[31:0], 32'h0000_1234);

    // R9 / R4 sticky pending with event enable gating
    wr_ctl(2'b11, 32'd0, 32'd0);
    wr_cnt(2'b01, 32'd0, 32'd0);
    wr_ctl(2'b01, cw(2'b11, 1'b0, 1'b0, 28'd0), 32'd0);
    ticks(1);
    check("R9 masked event", {31'd0, event_o[0]}, 32'd0);
    check("R4 R9 pending bit read", ctl_rd_data[31:0], cw(2'b11, 1'b0, 1'b1, 28'd0));
    wr_ctl(2'b01, cw(2'b11, 1'b1, 1'b1, 28'd0), 32'd0);
    check("R9 write 1 keeps, enable shows", {31'd0, event_o[0]}, 32'd1);
    wr_ctl(2'b01, cw(2'b11, 1'b1, 1'b0, 28'd0), 32'd0);
    check("R9 write 0 clears", {31'd0, event_o[0]}, 32'd0);
    wr_ctl(2'b10, 32'd0, cw(2'b00, 1'b1, 1'b1, 28'd9));
    check("R9 write 1 does not set", ctl_rd_data[63:32], cw(2'b00, 1'b1, 1'b0, 28'd9));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule